// File: doc/BRIEF.md
# Block-Mode Byte DMA Channel

This block is a single DMA channel that copies bytes between a word-wide system memory and a byte-wide peripheral stream, in either direction. Software programs it through a small register port. It sets a start byte address and a block word that holds two 16-bit counts. It then writes a channel control word. The transfer starts only when that control word matches one of the recognised direction codes exactly. The block count is the upper half of the block word and the words-per-block count is the lower half. Their product times four gives the number of bytes moved. The byte address advances by one for every byte.

Bytes read from memory are taken from the lane selected by the low two address bits. Bytes from the peripheral are written back to memory with a single active byte enable on the matching lane. When the last byte has moved, the channel does three things on the same clock edge. It clears the busy bit (bit 24 of the control word). It writes the address just past the last byte back into the address register. It raises a one-cycle interrupt that is also latched into a sticky status bit.

Top module: `dma_block_channel`

## Requirements
- R1: After reset, the address, block, control and status registers read zero. `irq`, `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: The number of bytes moved is (block[31:16] × block[15:0]) × 4. Bytes are moved in increasing byte-address order. The memory word address is byte address[ADDR_W-1:2], and the byte lane is byte address[1:0].
- R3: A control write of exactly 0x01000201 starts a memory-to-peripheral transfer. Each byte is read from memory and then offered on `tx_data` with `tx_valid`.
- R4: A control write of exactly 0x01000200 or 0x41000200 starts a peripheral-to-memory transfer. Each byte accepted on `rx_data` is written with `mem_we` high, `mem_be` one-hot at bit address[1:0], and the byte copied onto all four lanes of `mem_wdata`. Bytes outside the range are untouched.
- R5: Any other control value starts nothing: no memory request, no stream activity and no interrupt. The value is stored with bit 24 forced to 0.
- R6: On completion, control bit 24 reads 0. The address register reads the start address plus the byte count, modulo 2^ADDR_W.
- R7: `irq` is high for exactly one cycle per transfer. Status bit 0 is set with it. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R8: A block count of zero or a block size of zero moves no data. Completion is still signalled with the interrupt, and the address is unchanged.
- R9: While bit 24 is set, writes to the address, block and control registers are ignored.
- R10: `mem_req` is held with a stable address and direction until `mem_gnt`. `tx_valid` is held with stable data until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 block, 2 control, 3 status |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Registered read data, one cycle after rd_sel |
| irq | output | 1 | One-cycle completion interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant; completes the request in that cycle |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Peripheral accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Channel accepts incoming byte |
| rx_data | input | 8 | Incoming byte |

## Verification
The bench builds the channel with ADDR_W = 10, which gives a 256-word memory model that can be fully inspected after each transfer. This makes the byte-lane placement at unaligned starts, the untouched neighbour bytes and the written-back address all directly checkable. The 16-bit count fields stay at their default width, so zero-count and zero-size blocks and the exact-code decode are exercised with register values of the real width. Pseudo-random grant, ready and valid patterns stretch every handshake state, so that the hold rules and the busy-write lockout are each tested over several idle cycles.

// File: rtl/dma_block_pkg.sv
package dma_block_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int LANE_W  = $clog2(LANES);

  localparam logic [31:0] CODE_TX     = 32'h0100_0201;
  localparam logic [31:0] CODE_RX     = 32'h0100_0200;
  localparam logic [31:0] CODE_RX_ALT = 32'h4100_0200;
  localparam int          BUSY_BIT    = 24;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_BLK  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_TXS,
    ST_RXW,
    ST_MWR,
    ST_FIN
  } eng_state_t;
endpackage

// File: rtl/dma_block_regs.sv
module dma_block_regs
  import dma_block_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [31:0]         wr_data,
  input  logic [1:0]          rd_sel,
  output logic [31:0]         rd_data,
  output logic                irq,
  output logic                busy,
  output logic                sticky,
  output logic                start,
  output logic                dir_tx,
  output logic [ADDR_W-1:0]   base_addr,
  output logic [CNT_W-1:0]    blk_count,
  output logic [CNT_W-1:0]    blk_size,
  input  logic                done,
  input  logic [ADDR_W-1:0]   final_addr
);
  logic [ADDR_W-1:0]  madr_q;
  logic [2*CNT_W-1:0] blk_q;
  logic [31:0]        ctrl_q;
  logic               stat_q;
  logic               code_ok;

  assign code_ok = (wr_data == CODE_TX) || (wr_data == CODE_RX) ||
                   (wr_data == CODE_RX_ALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      madr_q  <= '0;
      blk_q   <= '0;
      ctrl_q  <= '0;
      stat_q  <= 1'b0;
      irq     <= 1'b0;
      start   <= 1'b0;
      rd_data <= '0;
    end else begin
      irq   <= 1'b0;
      start <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_ADDR: if (!ctrl_q[BUSY_BIT]) madr_q <= wr_data[ADDR_W-1:0];
          SEL_BLK:  if (!ctrl_q[BUSY_BIT]) blk_q <= wr_data[2*CNT_W-1:0];
          SEL_CTRL: if (!ctrl_q[BUSY_BIT]) begin
            if (code_ok) begin
              ctrl_q <= wr_data;
              start  <= 1'b1;
            end else begin
              ctrl_q <= wr_data & ~(32'd1 << BUSY_BIT);
            end
          end
          default:  if (wr_data[0]) stat_q <= 1'b0;
        endcase
      end
      if (done) begin
        ctrl_q[BUSY_BIT] <= 1'b0;
        madr_q           <= final_addr;
        irq              <= 1'b1;
        stat_q           <= 1'b1;
      end
      case (rd_sel)
        SEL_ADDR: rd_data <= 32'(madr_q);
        SEL_BLK:  rd_data <= 32'(blk_q);
        SEL_CTRL: rd_data <= ctrl_q;
        default:  rd_data <= {31'd0, stat_q};
      endcase
    end
  end

  assign busy      = ctrl_q[BUSY_BIT];
  assign sticky    = stat_q;
  assign dir_tx    = ctrl_q[0];
  assign base_addr = madr_q;
  assign blk_count = blk_q[2*CNT_W-1:CNT_W];
  assign blk_size  = blk_q[CNT_W-1:0];
endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
  import dma_block_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                dir_tx,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [CNT_W-1:0]    blk_count,
  input  logic [CNT_W-1:0]    blk_size,
  output logic                done,
  output logic [ADDR_W-1:0]   final_addr,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [LANES-1:0]    mem_be,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_gnt,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [7:0]          tx_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [7:0]          rx_data
);
  localparam int PROD_W = 2 * CNT_W;
  localparam int LEN_W  = PROD_W + LANE_W;

  eng_state_t        state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  left_q;
  logic [7:0]        byte_q;
  logic              tx_q;
  logic [PROD_W-1:0] prod;
  logic [LEN_W-1:0]  total;
  logic              last;
  eng_state_t        next_beat;

  assign prod      = PROD_W'(blk_count) * PROD_W'(blk_size);
  assign total     = {prod, {LANE_W{1'b0}}};
  assign last      = (left_q == LEN_W'(1));
  assign next_beat = last ? ST_FIN : (tx_q ? ST_MRD : ST_RXW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      byte_q  <= '0;
      tx_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          cur_q  <= base_addr;
          left_q <= total;
          tx_q   <= dir_tx;
          if (total == '0) state_q <= ST_FIN;
          else             state_q <= dir_tx ? ST_MRD : ST_RXW;
        end
        ST_MRD: if (mem_gnt) begin
          byte_q  <= mem_rdata[8*cur_q[LANE_W-1:0] +: 8];
          state_q <= ST_TXS;
        end
        ST_TXS: if (tx_ready) begin
          cur_q   <= cur_q + 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= next_beat;
        end
        ST_RXW: if (rx_valid) begin
          byte_q  <= rx_data;
          state_q <= ST_MWR;
        end
        ST_MWR: if (mem_gnt) begin
          cur_q   <= cur_q + 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= next_beat;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = (state_q == ST_MRD) || (state_q == ST_MWR);
  assign mem_we     = (state_q == ST_MWR);
  assign mem_addr   = cur_q[ADDR_W-1:LANE_W];
  assign mem_be     = mem_we ? (LANES'(1) << cur_q[LANE_W-1:0]) : '1;
  assign mem_wdata  = {LANES{byte_q}};
  assign tx_valid   = (state_q == ST_TXS);
  assign tx_data    = byte_q;
  assign rx_ready   = (state_q == ST_RXW);
  assign done       = (state_q == ST_FIN);
  assign final_addr = cur_q;
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel
  import dma_block_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_gnt,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  logic              busy_w;
  logic              sticky_w;
  logic              start_w;
  logic              dir_tx_w;
  logic              done_w;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] final_w;
  logic [CNT_W-1:0]  bcnt_w;
  logic [CNT_W-1:0]  bsize_w;

  dma_block_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .busy(busy_w), .sticky(sticky_w),
    .start(start_w), .dir_tx(dir_tx_w),
    .base_addr(base_w), .blk_count(bcnt_w), .blk_size(bsize_w),
    .done(done_w), .final_addr(final_w)
  );

  dma_block_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst),
    .start(start_w), .dir_tx(dir_tx_w),
    .base_addr(base_w), .blk_count(bcnt_w), .blk_size(bsize_w),
    .done(done_w), .final_addr(final_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );
endmodule

// File: rtl/dma_block_channel_chk.sv
module dma_block_channel_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              busy,
  input logic              sticky,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              rx_ready
);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> sticky);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));

  assert_write_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($onehot0(mem_be) && (mem_be != 4'd0)));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind dma_block_channel dma_block_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .busy(busy_w), .sticky(sticky_w),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_be(mem_be),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready)
);

// File: tb/dma_block_channel_test.sv
`timescale 1ns/1ps
module dma_block_channel_test;
  localparam int AW    = 10;
  localparam int WORDS = 1 << (AW - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        mem_req, mem_we, mem_gnt;
  logic [AW-3:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_data_unused;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dma_block_channel #(.ADDR_W(AW), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  assign tx_data_unused = 1'b0;

  // memory model
  logic [31:0] mem [WORDS];
  assign mem_rdata = mem[mem_addr];

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] rx_byte(int k);
    return 8'((k * 13 + 91) & 255);
  endfunction
  function automatic logic [7:0] mem_byte(int a);
    return mem[a >> 2][8 * (a & 3) +: 8];
  endfunction

  // handshake stimulus
  logic [15:0] lfsr = 16'hACE1;
  int rx_idx = 0;
  int tx_cnt = 0;
  int rx_cnt = 0;
  int req_cnt = 0;
  int irq_cnt = 0;
  logic irq_prev = 1'b0;
  int irq_wide = 0;
  logic [7:0] tx_cap [128];

  assign mem_gnt  = lfsr[0] | lfsr[3];
  assign tx_ready = lfsr[5];
  assign rx_valid = lfsr[7] | lfsr[2];
  assign rx_data  = rx_byte(rx_idx);

  always @(negedge clk)
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
    if (mem_req) req_cnt <= req_cnt + 1;
    if (tx_valid && tx_ready) begin
      if (tx_cnt < 128) tx_cap[tx_cnt] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    if (rx_valid && rx_ready) begin
      rx_idx <= rx_idx + 1;
      rx_cnt <= rx_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
    if (irq && irq_prev) irq_wide <= irq_wide + 1;
    irq_prev <= irq;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    tx_cnt = 0; rx_cnt = 0; req_cnt = 0; rx_idx = 0;
  endtask

  task automatic wait_irq(int start_cnt, int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq_cnt != start_cnt) begin ok = 1'b1; break; end
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "tx_valid", 32'(tx_valid), 0);
    chk("R1", "rx_ready", 32'(rx_ready), 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1", "register", v, 0);
    end
  endtask

  task automatic test_tx();
    logic [31:0] v; bit ok; int ic;
    clear_counts();
    wr(2'd0, 32'h041);
    wr(2'd1, 32'h0002_0003);
    ic = irq_cnt;
    wr(2'd2, 32'h0100_0201);
    wait_irq(ic, 2000, ok);
    chk("R3", "tx completion", 32'(ok), 1);
    chk("R2", "tx byte count", 32'(tx_cnt), 24);
    for (int k = 0; k < 24; k++)
      chk("R2", "tx byte order/lane", 32'(tx_cap[k]), 32'(init_byte(32'h41 + k)));
    rd(2'd0, v); chk("R6", "tx final address", v, 32'h059);
    rd(2'd2, v); chk("R6", "busy cleared", v, 32'h0000_0201);
    rd(2'd3, v); chk("R7", "sticky set", v, 1);
    chk("R7", "single interrupt", 32'(irq_cnt - ic), 1);
  endtask

  task automatic test_sticky();
    logic [31:0] v;
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R7", "write 0 keeps sticky", v, 1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R7", "write 1 clears sticky", v, 0);
  endtask

  task automatic test_rx(logic [31:0] code, int base, logic [31:0] blk, int n);
    logic [31:0] v; bit ok; int ic;
    clear_counts();
    wr(2'd0, 32'(base));
    wr(2'd1, blk);
    ic = irq_cnt;
    wr(2'd2, code);
    wait_irq(ic, 2000, ok);
    chk("R4", "rx completion", 32'(ok), 1);
    chk("R2", "rx byte count", 32'(rx_cnt), 32'(n));
    for (int k = 0; k < n; k++)
      chk("R4", "rx byte in memory", 32'(mem_byte(base + k)), 32'(rx_byte(k)));
    chk("R4", "byte below untouched", 32'(mem_byte(base - 1)), 32'(init_byte(base - 1)));
    chk("R4", "byte above untouched", 32'(mem_byte(base + n)), 32'(init_byte(base + n)));
    rd(2'd0, v); chk("R6", "rx final address", v, 32'(base + n));
    rd(2'd2, v); chk("R6", "rx busy cleared", v, code & ~32'h0100_0000);
    wr(2'd3, 32'h1);
  endtask

  task automatic test_unknown(logic [31:0] code);
    logic [31:0] v; int ic;
    clear_counts();
    wr(2'd0, 32'h090);
    wr(2'd1, 32'h0001_0001);
    ic = irq_cnt;
    wr(2'd2, code);
    repeat (40) @(negedge clk);
    chk("R5", "no interrupt", 32'(irq_cnt - ic), 0);
    chk("R5", "no memory request", 32'(req_cnt), 0);
    chk("R5", "no tx beat", 32'(tx_cnt), 0);
    chk("R5", "no rx beat", 32'(rx_cnt), 0);
    rd(2'd2, v); chk("R5", "stored without bit 24", v, code & ~32'h0100_0000);
    rd(2'd0, v); chk("R5", "address unchanged", v, 32'h090);
  endtask

  task automatic test_zero(logic [31:0] blk, logic [31:0] code);
    logic [31:0] v; bit ok; int ic;
    clear_counts();
    wr(2'd0, 32'h080);
    wr(2'd1, blk);
    ic = irq_cnt;
    wr(2'd2, code);
    wait_irq(ic, 10, ok);
    chk("R8", "zero length signals completion", 32'(ok), 1);
    repeat (4) @(negedge clk);
    chk("R8", "no memory request", 32'(req_cnt), 0);
    chk("R8", "no stream beat", 32'(tx_cnt + rx_cnt), 0);
    rd(2'd0, v); chk("R8", "address unchanged", v, 32'h080);
    rd(2'd2, v); chk("R8", "busy cleared", v, code & ~32'h0100_0000);
    wr(2'd3, 32'h1);
  endtask

  task automatic test_busy_writes();
    logic [31:0] v; bit ok; int ic;
    clear_counts();
    wr(2'd0, 32'h300);
    wr(2'd1, 32'h0004_0004);
    ic = irq_cnt;
    wr(2'd2, 32'h0100_0201);
    wr(2'd0, 32'h010);
    wr(2'd1, 32'h0001_0001);
    wr(2'd2, 32'h0100_0200);
    rd(2'd2, v); chk("R9", "control kept while busy", v, 32'h0100_0201);
    wait_irq(ic, 4000, ok);
    chk("R9", "busy transfer completes", 32'(ok), 1);
    chk("R9", "length kept", 32'(tx_cnt), 64);
    chk("R9", "no rx beats", 32'(rx_cnt), 0);
    rd(2'd0, v); chk("R9", "address write ignored", v, 32'h340);
    rd(2'd1, v); chk("R9", "block write ignored", v, 32'h0004_0004);
    for (int k = 0; k < 64; k++)
      chk("R3", "long tx data", 32'(tx_cap[k]), 32'(init_byte(32'h300 + k)));
    wr(2'd3, 32'h1);
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < 4; b++)
        mem[w][8*b +: 8] = init_byte(4 * w + b);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_tx();
    test_sticky();
    test_rx(32'h0100_0200, 32'h102, 32'h0001_0002, 8);
    test_rx(32'h4100_0200, 32'h200, 32'h0003_0001, 12);
    test_unknown(32'h0100_0202);
    test_unknown(32'h0000_0201);
    test_zero(32'h0000_0005, 32'h0100_0201);
    test_zero(32'h0003_0000, 32'h0100_0200);
    test_busy_writes();
    chk("R7", "interrupt never wider than one cycle", 32'(irq_wide), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule